// File: doc/BRIEF.md
# Word-Programming Pulse/Verify Sequencer

This controller writes a word-wide one-time or erasable non-volatile memory, one address after another. For each word it presents the address and the data from a data-source port, lowers the chip-enable strobe for a fixed number of clock cycles, releases the bus and reads the word back with output-enable low. If the read-back differs from the intended data, it applies another pulse. It does this up to a retry ceiling, and never adds an extra "safety" pulse once a word reads correctly. When the ceiling is reached without a match, it stops and reports the failing address.

Once the last word is written, the sequencer re-reads the whole range and compares every word with the data source. It does this once for each supply level requested by a parameter. The analog supplies are handled outside the block. The sequencer only raises a request flag and names the level it currently needs. A single start pulse runs the whole job, which ends either in a one-cycle done pulse or in a fail flag that stays set.

The data source is combinational: for the address on `dev_addr` it returns the intended word in the same cycle.

Top module: `wordprog_seq`

## Requirements
- R1: After reset the block is idle with `dev_ce_n`=1, `dev_oe_n`=1, bus released, `supply_req`=0, `supply_sel`=0, `done`=0 and `fail`=0. A `start` seen while idle captures `base_addr`/`last_addr` (base ≤ last assumed) and begins at the base address. `supply_req` is 1 from the next cycle until the block returns to idle.
- R2: A program step drives the bus with the source word and holds `dev_oe_n`=1. It holds address and data for SETUP_CYC cycles with `dev_ce_n`=1, then PULSE_CYC cycles with `dev_ce_n`=0, then HOLD_CYC cycles with `dev_ce_n`=1.
- R3: After each pulse the bus is released for TURN_CYC cycles. Then `dev_oe_n` is 0 for ACCESS_CYC cycles with `dev_ce_n`=1, and the bus is compared in the last of those cycles. After the read, `dev_oe_n`=1 and the bus stays released for TURN_CYC cycles before anything is driven again.
- R4: A word that reads back correctly gets no further pulse. The block moves to the next address, and the pulse count restarts at zero there. The address never passes the captured last address.
- R5: If MAX_PULSES pulses have been applied to one word and the read-back after the last of them still differs, the block goes idle with `fail`=1 and `fail_addr` set to that word. No further pulses are applied.
- R6: After the last word verifies, the range from base to last is read again once per level, LEVELS times. Each word is read with `dev_oe_n` held low for ACCESS_CYC cycles, with no turnaround between words. `supply_sel` is the pass number (1 to LEVELS) during these passes and 0 at all other times.
- R7: A mismatch during a re-read pass sends the block idle with `fail`=1 and `fail_addr` set to the mismatching address.
- R8: After the final comparison of the last pass, `done` is 1 for exactly one cycle. `done` and `fail` are never 1 together. `fail` stays set until the next `start`, which clears it.
- R9: `start` has no effect while a job is running.
- R10: With base equal to last, a single word is programmed and re-checked. A word that needs exactly MAX_PULSES pulses still passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job when idle |
| base_addr | input | ADDR_W | First address of the range |
| last_addr | input | ADDR_W | Last address of the range |
| src_data | input | DATA_W | Intended word for the address on dev_addr |
| dev_addr | output | ADDR_W | Memory address |
| dev_ce_n | output | 1 | Chip enable, active low (program pulse) |
| dev_oe_n | output | 1 | Output enable, active low (read) |
| dev_dq | inout | DATA_W | Bidirectional memory data bus |
| supply_req | output | 1 | Request for program/verify supplies |
| supply_sel | output | LVW | 0 while programming, pass number during re-read |
| done | output | 1 | One-cycle successful-completion pulse |
| fail | output | 1 | Sticky failure flag |
| fail_addr | output | ADDR_W | Address that caused the failure |

## Verification
On every cycle the assertions check the following. The chip-enable pulse never overlaps output-enable. The address stays fixed while the pulse is low. Output-enable only falls after a cycle with the bus released. The per-word pulse count stays at or below its ceiling, and the address stays inside the captured range. Done is a single cycle and never coincides with fail, and fail stays set until a start. Only the bench's scenarios can show the rest. These are the exact lengths of setup, pulse, hold, turnaround and access windows, and the number of pulses each word receives for a given device response. They also cover stopping at the retry ceiling versus passing exactly at it, a failure found only in the second re-read pass, and the reported address. Finally they show that a start arriving mid-job is ignored.

// File: rtl/wp_pkg.sv
// Shared types for the word-programming sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package wp_pkg;

    // Phase of the sequencer; one phase is active per cycle.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_TURN,
        ST_READ,
        ST_GAP,
        ST_CHECK
    } wp_state_e;

    // Where the post-read turnaround leads.
    typedef enum logic [1:0] {
        GN_REPEAT,
        GN_STEP,
        GN_CHECK
    } wp_gap_next_e;

endpackage

// File: rtl/wp_timer.sv
// Down-counting phase timer.
// Loading N-1 makes the current phase last exactly N cycles:
// 'expired' is high in the last cycle of the phase.
// Assumes: every loaded value is below 2**CW.
module wp_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Reload on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/wp_addr_walk.sv
// Address walker: captures the range at start, then steps through it
// and can rewind to the base for each re-read pass.
// Assumes: base <= last and no step is requested at the last address.
module wp_addr_walk #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          capture,
    input  logic [AW-1:0] base_in,
    input  logic [AW-1:0] last_in,
    input  logic          step,
    input  logic          rewind,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] last_q;

    // Hold the range captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            last_q <= '0;
        end else if (capture) begin
            base_q <= base_in;
            last_q <= last_in;
        end
    end

    // Current address: load base, advance, or return to base.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (capture)
            addr <= base_in;
        else if (rewind)
            addr <= base_q;
        else if (step)
            addr <= addr + 1'b1;
    end

    assign at_last = (addr == last_q);

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !capture) |-> (addr <= last_q))
        else $error("address beyond captured last address"); // R4

endmodule

// File: rtl/wp_pulse_ctr.sv
// Per-word pulse counter: cleared for each new word, incremented per pulse.
// Assumes: the controller never increments once the ceiling is reached.
module wp_pulse_ctr #(
    parameter int MAXP = 25,
    localparam int PCW = $clog2(MAXP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_max
);
    logic [PCW-1:0] count;

    // Count pulses applied to the current word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end

    assign at_max = (count == PCW'(MAXP));

    AST_PULSE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PCW'(MAXP))
        else $error("pulse count above ceiling"); // R5

endmodule

// File: rtl/wordprog_seq.sv
// Word-programming pulse/verify sequencer.
// Programs base..last one word at a time: setup, enable pulse, hold,
// turnaround, read-back. A word is retried up to MAX_PULSES pulses and
// gets no pulse after it reads back correctly. The range is then
// re-read once per supply level.
// Assumes: src_data is combinational in dev_addr, base_addr <= last_addr
// at start, and every *_CYC parameter is at least 1.
module wordprog_seq
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int PULSE_CYC  = 5000,
    parameter int SETUP_CYC  = 2,
    parameter int HOLD_CYC   = 2,
    parameter int ACCESS_CYC = 3,
    parameter int TURN_CYC   = 2,
    parameter int MAX_PULSES = 25,
    parameter int LEVELS     = 2,
    localparam int LVW       = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              dev_ce_n,
    output logic              dev_oe_n,
    inout  wire  [DATA_W-1:0] dev_dq,
    output logic              supply_req,
    output logic [LVW-1:0]    supply_sel,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int MAX_A = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int MAX_B = (ACCESS_CYC > TURN_CYC) ? ACCESS_CYC : TURN_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXC  = (PULSE_CYC > MAX_C) ? PULSE_CYC : MAX_C;
    localparam int CW    = $clog2(MAXC + 1);

    wp_state_e    state, nxt;
    wp_gap_next_e gap_nxt, gap_d;
    logic [LVW-1:0] level;

    logic          tmr_load, tmr_exp;
    logic [CW-1:0] tmr_val;
    logic          w_cap, w_step, w_rew, w_last;
    logic          p_clr, p_inc, p_max;
    logic          lvl_clr, lvl_inc, set_done, set_fail;
    logic          drive_en, match, active;

    assign active = (state != ST_IDLE);
    assign match  = (dev_dq == src_data);

    wp_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    wp_addr_walk #(.AW(ADDR_W)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .capture (w_cap),
        .base_in (base_addr),
        .last_in (last_addr),
        .step    (w_step),
        .rewind  (w_rew),
        .addr    (dev_addr),
        .at_last (w_last)
    );

    wp_pulse_ctr #(.MAXP(MAX_PULSES)) u_pulses (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (p_clr),
        .inc    (p_inc),
        .at_max (p_max)
    );

    // Next phase and the side effects of leaving the current one.
    always_comb begin
        nxt      = state;
        gap_d    = gap_nxt;
        tmr_load = 1'b0;
        tmr_val  = '0;
        w_cap    = 1'b0;
        w_step   = 1'b0;
        w_rew    = 1'b0;
        p_clr    = 1'b0;
        p_inc    = 1'b0;
        lvl_clr  = 1'b0;
        lvl_inc  = 1'b0;
        set_done = 1'b0;
        set_fail = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                nxt      = ST_SETUP;
                w_cap    = 1'b1;
                p_clr    = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CW'(SETUP_CYC - 1);
            end
            ST_SETUP: if (tmr_exp) begin
                nxt      = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CW'(PULSE_CYC - 1);
            end
            ST_PULSE: if (tmr_exp) begin
                nxt      = ST_HOLD;
                p_inc    = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CW'(HOLD_CYC - 1);
            end
            ST_HOLD: if (tmr_exp) begin
                nxt      = ST_TURN;
                tmr_load = 1'b1;
                tmr_val  = CW'(TURN_CYC - 1);
            end
            ST_TURN: if (tmr_exp) begin
                nxt      = ST_READ;
                tmr_load = 1'b1;
                tmr_val  = CW'(ACCESS_CYC - 1);
            end
            ST_READ: if (tmr_exp) begin
                if (match) begin
                    gap_d    = w_last ? GN_CHECK : GN_STEP;
                    nxt      = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(TURN_CYC - 1);
                end else if (p_max) begin
                    nxt      = ST_IDLE;
                    set_fail = 1'b1;
                end else begin
                    gap_d    = GN_REPEAT;
                    nxt      = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(TURN_CYC - 1);
                end
            end
            ST_GAP: if (tmr_exp) begin
                tmr_load = 1'b1;
                case (gap_nxt)
                    GN_STEP: begin
                        nxt     = ST_SETUP;
                        w_step  = 1'b1;
                        p_clr   = 1'b1;
                        tmr_val = CW'(SETUP_CYC - 1);
                    end
                    GN_CHECK: begin
                        nxt     = ST_CHECK;
                        w_rew   = 1'b1;
                        lvl_clr = 1'b1;
                        tmr_val = CW'(ACCESS_CYC - 1);
                    end
                    default: begin
                        nxt     = ST_SETUP;
                        tmr_val = CW'(SETUP_CYC - 1);
                    end
                endcase
            end
            ST_CHECK: if (tmr_exp) begin
                if (!match) begin
                    nxt      = ST_IDLE;
                    set_fail = 1'b1;
                end else if (!w_last) begin
                    w_step   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(ACCESS_CYC - 1);
                end else if (level == LVW'(LEVELS - 1)) begin
                    nxt      = ST_IDLE;
                    set_done = 1'b1;
                end else begin
                    lvl_inc  = 1'b1;
                    w_rew    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(ACCESS_CYC - 1);
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Phase register and post-read routing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            gap_nxt <= GN_REPEAT;
        end else begin
            state   <= nxt;
            gap_nxt <= gap_d;
        end
    end

    // Re-read pass index.
    always_ff @(posedge clk) begin
        if (!rst_n || lvl_clr)
            level <= '0;
        else if (lvl_inc)
            level <= level + 1'b1;
    end

    // Completion pulse, sticky failure and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
        end else begin
            done <= set_done;
            if (set_fail) begin
                fail      <= 1'b1;
                fail_addr <= dev_addr;
            end else if (w_cap) begin
                fail <= 1'b0;
            end
        end
    end

    // Strobe, bus and supply decode from the phase.
    assign drive_en   = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
    assign dev_ce_n   = (state != ST_PULSE);
    assign dev_oe_n   = !((state == ST_READ) || (state == ST_CHECK));
    assign dev_dq     = drive_en ? src_data : 'z;
    assign supply_req = active;
    assign supply_sel = (state == ST_CHECK) ? level + 1'b1 : '0;

    AST_PULSE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_ce_n |-> dev_oe_n)
        else $error("output enable low during pulse"); // R2

    AST_PULSE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n && $past(!dev_ce_n)) |-> $stable(dev_addr))
        else $error("address moved during pulse"); // R2

    AST_READ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_oe_n) |-> $past(!drive_en))
        else $error("read began right after a driven cycle"); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle"); // R8

    AST_DONE_NOT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail))
        else $error("done and fail together"); // R8

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail)
        else $error("fail cleared without start"); // R8

    AST_IDLE_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) && !start |-> !supply_req)
        else $error("supply request while finished"); // R1

endmodule

// File: tb/wordprog_seq_test.sv
// Bench: a behavioural device model plus a queue of expected per-cycle
// outputs built from the requirements, compared on every clock.
module wordprog_seq_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int PC = 4;
    localparam int SC = 2;
    localparam int HC = 2;
    localparam int AC = 3;
    localparam int TC = 2;
    localparam int MP = 25;
    localparam int LV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] src_data;
    logic [AW-1:0] dev_addr;
    logic dev_ce_n, dev_oe_n, supply_req, done, fail;
    logic [1:0] supply_sel;
    logic [AW-1:0] fail_addr;
    wire  [DW-1:0] dq;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wordprog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PC), .SETUP_CYC(SC),
        .HOLD_CYC(HC), .ACCESS_CYC(AC), .TURN_CYC(TC),
        .MAX_PULSES(MP), .LEVELS(LV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_addr(base_addr), .last_addr(last_addr), .src_data(src_data),
        .dev_addr(dev_addr), .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n),
        .dev_dq(dq), .supply_req(supply_req), .supply_sel(supply_sel),
        .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a, ~a} ^ 16'h1234;
    endfunction

    assign src_data = pat(dev_addr);

    // Device model: a word takes need[a] pulses to hold its data.
    logic [DW-1:0] mem [256];
    int need [256];
    int cnt [256];
    logic [AW-1:0] drop_addr = '1;
    logic [1:0]    drop_lvl = 2'd3;
    logic prev_ce = 1'b1;
    logic [DW-1:0] rd_val;

    assign rd_val = mem[dev_addr] ^
        ((dev_addr == drop_addr && supply_sel == drop_lvl) ? 16'h0001 : 16'h0000);
    assign dq = (!dev_oe_n && dev_ce_n) ? rd_val : 'z;

    always @(negedge clk) begin
        if (!prev_ce && dev_ce_n && dev_oe_n) begin
            cnt[dev_addr] = cnt[dev_addr] + 1;
            if (cnt[dev_addr] >= need[dev_addr]) mem[dev_addr] = dq;
        end
        prev_ce = dev_ce_n;
    end

    typedef struct {
        bit busy; bit ce_n; bit oe_n; int oetag; bit drv;
        logic [AW-1:0] addr; logic [1:0] sel;
        bit done; bit fail; int ftag; logic [AW-1:0] faddr;
    } exp_t;
    exp_t trace[$];

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h (cycle %0d)",
                     req, what, act, exp, cycles);
        end
    endtask

    function automatic void push(bit busy, bit ce_n, bit oe_n, int oetag, bit drv,
                                 logic [AW-1:0] a, logic [1:0] sel,
                                 bit dn, bit fl, int ftag, logic [AW-1:0] fa);
        exp_t e;
        e.busy = busy; e.ce_n = ce_n; e.oe_n = oe_n; e.oetag = oetag; e.drv = drv;
        e.addr = a; e.sel = sel; e.done = dn; e.fail = fl; e.ftag = ftag; e.faddr = fa;
        trace.push_back(e);
    endfunction

    // Expected outputs for one job, per R2..R8.
    task automatic build(input int b, input int l, input int dlvl, input int dadr);
        bit ok = 1;
        int fa = 0;
        int ft = 5;
        for (int a = b; a <= l && ok; a++) begin
            int n = (need[a] > MP) ? MP : need[a];
            for (int i = 1; i <= n; i++) begin
                for (int k = 0; k < SC; k++) push(1,1,1,2,1,a,0,0,0,5,0); // R2 setup
                for (int k = 0; k < PC; k++) push(1,0,1,2,1,a,0,0,0,5,0); // R2 pulse
                for (int k = 0; k < HC; k++) push(1,1,1,2,1,a,0,0,0,5,0); // R2 hold
                for (int k = 0; k < TC; k++) push(1,1,1,3,0,a,0,0,0,5,0); // R3 turn
                for (int k = 0; k < AC; k++) push(1,1,0,3,0,a,0,0,0,5,0); // R3 read
                if (i == MP && need[a] > MP) begin ok = 0; fa = a; ft = 5; break; end
                for (int k = 0; k < TC; k++) push(1,1,1,3,0,a,0,0,0,5,0); // R3 gap
            end
        end
        for (int lv = 1; lv <= LV && ok; lv++) begin
            for (int a = b; a <= l && ok; a++) begin
                for (int k = 0; k < AC; k++) push(1,1,0,6,0,a,2'(lv),0,0,7,0); // R6
                if (lv == dlvl && a == dadr) begin ok = 0; fa = a; ft = 7; end // R7
            end
        end
        push(0,1,1,1,0,0,0,ok,!ok,ft,AW'(fa)); // R8 end of job
        push(0,1,1,1,0,0,0,0,!ok,ft,AW'(fa)); // R8 done single, fail held
    endtask

    task automatic compare(input exp_t e);
        chk(supply_req == e.busy, 1, "supply_req", 32'(supply_req), 32'(e.busy));
        chk(dev_ce_n == e.ce_n, 2, "dev_ce_n", 32'(dev_ce_n), 32'(e.ce_n));
        chk(dev_oe_n == e.oe_n, e.oetag, "dev_oe_n", 32'(dev_oe_n), 32'(e.oe_n));
        if (e.busy) chk(dev_addr == e.addr, 4, "dev_addr", 32'(dev_addr), 32'(e.addr));
        if (e.drv) chk(dq == pat(e.addr), 2, "dev_dq", 32'(dq), 32'(pat(e.addr)));
        chk(supply_sel == e.sel, 6, "supply_sel", 32'(supply_sel), 32'(e.sel));
        chk(done == e.done, 8, "done", 32'(done), 32'(e.done));
        chk(fail == e.fail, e.ftag, "fail", 32'(fail), 32'(e.fail));
        if (e.fail) chk(fail_addr == e.faddr, e.ftag, "fail_addr", 32'(fail_addr), 32'(e.faddr));
    endtask

    // Run one job; a stray start is injected at cycle 'poke' (R9) if >= 0.
    task automatic run(input int b, input int l, input int dlvl, input int dadr, input int poke);
        int idx = 0;
        drop_lvl = 2'(dlvl);
        drop_addr = AW'(dadr);
        trace.delete();
        build(b, l, dlvl, dadr);
        base_addr = AW'(b);
        last_addr = AW'(l);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base_addr = 8'hF0;
        last_addr = 8'hF8;
        while (trace.size() > 0) begin
            compare(trace.pop_front());
            start = (idx == poke); // R9: must be ignored
            idx++;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'hFFFF;
            need[i] = 1;
            cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!supply_req && dev_ce_n && dev_oe_n && supply_sel == 0, 1, "reset strobes",
            {supply_req, dev_ce_n, dev_oe_n}, 32'b011);
        chk(!done && !fail, 1, "reset flags", {done, fail}, 0);

        // R4/R9: mixed pulse counts, stray start mid-job
        need[3] = 1; need[4] = 2; need[5] = 1; need[6] = 3; need[7] = 1;
        run(3, 7, 0, 255, 30);
        // R5: word 10 never takes within the ceiling
        need[10] = 30;
        run(8, 10, 0, 255, -1);
        // R10: single word needing exactly the ceiling
        need[12] = MP;
        run(12, 12, 0, 255, -1);
        // R7: word 21 reads wrong only in the second pass
        run(20, 22, 2, 21, -1);
        // R6: a clean two-pass run after a failure (fail cleared, R8)
        run(30, 31, 0, 255, -1);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule